// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Selective Status Update

This block is the arithmetic and logic stage of a small 8-bit processor core. It takes two byte operands, the current status vector and a 4-bit operation code, and returns a byte result and a new status vector in the same cycle. Each operation carries its own mask of status bits it is allowed to rewrite. Every bit outside that mask passes from `flags_i` to `flags_o` unchanged, so the core can write the status vector back on every instruction without extra qualification.

A second, clocked path adds a 6-bit unsigned immediate to a 16-bit register pair, or subtracts it, given as high byte and low byte. It does the work as two 8-bit steps through a small state machine. The machine has three states. ST_IDLE waits for a start. The transition ST_IDLE→ST_LOWSTEP happens on a start pulse and captures the operands. The transition ST_LOWSTEP→ST_HIGHSTEP is unconditional: the low byte is computed there and its carry or borrow is kept. The transition ST_HIGHSTEP→ST_IDLE is also unconditional: the high byte is computed there, the 16-bit result and its flags are registered, and a one-cycle done pulse is raised. Register access and instruction decoding live outside the block.

Top module: `byteflag_alu`

## Requirements
- R1: Status bit positions are 0 C, 1 Z, 2 N, 3 V, 4 S, 5 H. Opcode 0 (add) gives a+b and opcode 1 (add with carry) gives a+b+C_in. Both set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, N to result bit 7 and Z to result==0.
- R2: Opcode 2 (subtract) gives a-b and opcode 3 (subtract with borrow) gives a-b-C_in. C is the borrow out of bit 7, H is the borrow into bit 4, V is signed overflow and N is bit 7. For opcode 2, Z is result==0. For opcode 3, Z is result==0 AND Z_in.
- R3: The logic opcodes give these results: 4 a AND b, 5 a OR b, 6 a XOR b, 7 a OR b (set bits), 8 a AND NOT b (clear bits), 11 a (test) and 12 zero (clear). Each sets Z and N from the result, clears V, and leaves C and H at their input values.
- R4: Opcode 9 gives a+1 with V=1 only for a=0x7F. Opcode 10 gives a-1 with V=1 only for a=0x80. Both set Z and N and leave C and H unchanged.
- R5: Opcode 13 gives 0xFF-a, sets C to 1, clears V, sets Z and N, and leaves H unchanged.
- R6: Opcode 14 gives 0x00-a. C is set when a is nonzero, H is set when a's low nibble is nonzero, and V is set only for a=0x80. Z and N come from the result.
- R7: Opcode 15 gives 0xFF and passes all six status bits through unchanged.
- R8: No byte opcode changes S; flags_o bit 4 always equals flags_i bit 4.
- R9: A start seen in ST_IDLE makes busy high in the next two cycles. done is high for exactly one cycle after that, with busy low. A start seen while busy is ignored, along with the operand and flag values that come with it.
- R10: When done is high, the word result is {hi,lo}+imm (wsub_i=0) or {hi,lo}-imm (wsub_i=1), modulo 2^16, with imm from 0 to 63. C is the 16-bit carry or borrow, Z is set when all 16 bits are zero, N is bit 15, V is signed 16-bit overflow and S=N XOR V. H keeps the value flags_i bit 5 had when the operation started. The word flags use the R1 bit positions.
- R11: During and after reset, busy and done are 0 and the word result and word flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the word path |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Byte operation code |
| a_i | input | 8 | First byte operand |
| b_i | input | 8 | Second byte operand or immediate |
| flags_i | input | 6 | Current status vector |
| res_o | output | 8 | Byte result |
| flags_o | output | 6 | Updated status vector |
| wstart_i | input | 1 | Start a word operation |
| wsub_i | input | 1 | 1 selects subtract on the word path |
| wlo_i | input | 8 | Low byte of the register pair |
| whi_i | input | 8 | High byte of the register pair |
| wimm_i | input | 6 | Unsigned word immediate |
| wbusy_o | output | 1 | Word path is stepping |
| wdone_o | output | 1 | Word result valid, one-cycle pulse |
| wres_o | output | 16 | Registered word result |
| wflags_o | output | 6 | Status vector after the word operation |

## Verification
Every byte opcode is swept over all 256 values of the first operand. For each one, the second operand takes sixteen evenly spaced values plus copies of the first operand, 0x80, 0x7F and 0x01. The spaced values reach both nibble boundaries, so H carry and no-carry cases appear. The copies give the equal-operand results where Z and a chained subtract must tell apart. 0x7F and 0x80 separate signed overflow from unsigned carry. The input status vector is hashed from the operands, so both values of the incoming carry and the incoming Z occur, and a bit that should have passed through but was rewritten shows up as a mismatch. The word path runs over the values around 0x0000, 0x00FF/0x0100, 0x7FFF/0x8000 and 0xFFFF, plus a spread of other values, with immediates 0, 1, 31, 62 and 63. This separates a carry across the byte boundary from a 16-bit wrap and a signed overflow. Altered operands and flags are presented during each busy window to show that a start in that window is ignored.

// File: rtl/bfalu_pkg.sv
package bfalu_pkg;

    localparam int FLAG_W = 6;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SETB = 4'd7,
        OP_CLRB = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_TST  = 4'd11,
        OP_CLR  = 4'd12,
        OP_COM  = 4'd13,
        OP_NEG  = 4'd14,
        OP_SER  = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOWSTEP  = 2'd1,
        ST_HIGHSTEP = 2'd2
    } wstate_e;

    // Status bits each opcode may rewrite; all others pass through.
    function automatic logic [FLAG_W-1:0] flag_mask(op_e op);
        logic [FLAG_W-1:0] m;
        m = '0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                m[FL_C] = 1'b1; m[FL_Z] = 1'b1; m[FL_N] = 1'b1;
                m[FL_V] = 1'b1; m[FL_H] = 1'b1;
            end
            OP_COM: begin
                m[FL_C] = 1'b1; m[FL_Z] = 1'b1; m[FL_N] = 1'b1; m[FL_V] = 1'b1;
            end
            OP_SER: m = '0;
            default: begin
                m[FL_Z] = 1'b1; m[FL_N] = 1'b1; m[FL_V] = 1'b1;
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bfalu_addsub.sv
module bfalu_addsub #(
    parameter int W  = 8,
    parameter int HB = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         half_o,
    output logic         ovf_o
);
    logic [W-1:0]  bx;
    logic          c0;
    logic [W:0]    full;
    logic [HB:0]   low;

    always_comb begin
        // Subtract runs as a + ~b + ~borrow; outgoing carries invert to borrows.
        bx     = sub_i ? ~b_i : b_i;
        c0     = sub_i ? ~cin_i : cin_i;
        full   = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, c0};
        low    = {1'b0, a_i[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, c0};
        sum_o  = full[W-1:0];
        cout_o = sub_i ? ~full[W] : full[W];
        half_o = sub_i ? ~low[HB] : low[HB];
        ovf_o  = (a_i[W-1] == bx[W-1]) && (full[W-1] != a_i[W-1]);
    end

endmodule

// File: rtl/bfalu_logic.sv
module bfalu_logic
    import bfalu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        case (op_i)
            OP_AND:          res_o = a_i & b_i;
            OP_OR, OP_SETB:  res_o = a_i | b_i;
            OP_XOR:          res_o = a_i ^ b_i;
            OP_CLRB:         res_o = a_i & ~b_i;
            OP_TST:          res_o = a_i;
            OP_CLR:          res_o = a_i ^ a_i;
            OP_COM:          res_o = ~a_i;
            OP_SER:          res_o = '1;
            default:         res_o = '0;
        endcase
    end

endmodule

// File: rtl/bfalu_byte_core.sv
module bfalu_byte_core
    import bfalu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]        op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [W-1:0]      res_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int HALF = W / 2;

    op_e               op;
    logic [W-1:0]      ad_a, ad_b, ad_sum, lg_res, res;
    logic              ad_cin, ad_sub, ad_cout, ad_half, ad_ovf;
    logic              use_adder;
    logic [FLAG_W-1:0] calc, mask;

    assign op = op_e'(op_i);

    always_comb begin
        ad_a      = a_i;
        ad_b      = b_i;
        ad_cin    = 1'b0;
        ad_sub    = 1'b0;
        use_adder = 1'b1;
        unique case (op)
            OP_ADD: ;
            OP_ADC: ad_cin = flags_i[FL_C];
            OP_SUB: ad_sub = 1'b1;
            OP_SBC: begin ad_sub = 1'b1; ad_cin = flags_i[FL_C]; end
            OP_INC: ad_b = {{(W-1){1'b0}}, 1'b1};
            OP_DEC: begin ad_b = {{(W-1){1'b0}}, 1'b1}; ad_sub = 1'b1; end
            OP_NEG: begin ad_a = '0; ad_b = a_i; ad_sub = 1'b1; end
            OP_AND, OP_OR, OP_XOR, OP_SETB, OP_CLRB,
            OP_TST, OP_CLR, OP_COM, OP_SER: use_adder = 1'b0;
        endcase
    end

    bfalu_addsub #(.W(W), .HB(HALF)) u_addsub (
        .a_i   (ad_a),
        .b_i   (ad_b),
        .cin_i (ad_cin),
        .sub_i (ad_sub),
        .sum_o (ad_sum),
        .cout_o(ad_cout),
        .half_o(ad_half),
        .ovf_o (ad_ovf)
    );

    bfalu_logic #(.W(W)) u_logic (
        .op_i (op),
        .a_i  (a_i),
        .b_i  (b_i),
        .res_o(lg_res)
    );

    always_comb begin
        res          = use_adder ? ad_sum : lg_res;
        mask         = flag_mask(op);
        calc[FL_C]   = (op == OP_COM) ? 1'b1 : ad_cout;
        // Subtract with borrow keeps Z sticky so multi-byte compares chain.
        calc[FL_Z]   = (res == '0) && ((op == OP_SBC) ? flags_i[FL_Z] : 1'b1);
        calc[FL_N]   = res[W-1];
        calc[FL_V]   = use_adder ? ad_ovf : 1'b0;
        calc[FL_S]   = calc[FL_N] ^ calc[FL_V];
        calc[FL_H]   = ad_half;
        res_o        = res;
        flags_o      = (flags_i & ~mask) | (calc & mask);
    end

endmodule

// File: rtl/bfalu_word_seq.sv
module bfalu_word_seq
    import bfalu_pkg::*;
#(
    parameter int W     = 8,
    parameter int IMM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sub_i,
    input  logic [W-1:0]      lo_i,
    input  logic [W-1:0]      hi_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              h_in_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [2*W-1:0]    res_o,
    output logic [FLAG_W-1:0] flags_o
);
    wstate_e          state_q, state_d;
    logic [W-1:0]     lo_q, hi_q, lo_res_q;
    logic [IMM_W-1:0] imm_q;
    logic             sub_q, h_q, cy_q;
    logic [W-1:0]     st_a, st_b, st_sum;
    logic             st_cin, st_cout, st_ovf;
    logic [W:0]       st_full;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_LOWSTEP;
            ST_LOWSTEP:  state_d = ST_HIGHSTEP;
            ST_HIGHSTEP: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // One shared 8-bit step: low byte with immediate, then high byte with carry.
    always_comb begin
        if (state_q == ST_LOWSTEP) begin
            st_a   = lo_q;
            st_b   = {{(W-IMM_W){1'b0}}, imm_q};
            st_cin = 1'b0;
        end else begin
            st_a   = hi_q;
            st_b   = '0;
            st_cin = cy_q;
        end
        if (sub_q) st_full = {1'b0, st_a} - {1'b0, st_b} - {{W{1'b0}}, st_cin};
        else       st_full = {1'b0, st_a} + {1'b0, st_b} + {{W{1'b0}}, st_cin};
        st_sum  = st_full[W-1:0];
        st_cout = st_full[W];
        st_ovf  = sub_q ? (hi_q[W-1] & ~st_sum[W-1]) : (~hi_q[W-1] & st_sum[W-1]);
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q     <= '0;
            hi_q     <= '0;
            imm_q    <= '0;
            sub_q    <= 1'b0;
            h_q      <= 1'b0;
            cy_q     <= 1'b0;
            lo_res_q <= '0;
            done_o   <= 1'b0;
            res_o    <= '0;
            flags_o  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        lo_q  <= lo_i;
                        hi_q  <= hi_i;
                        imm_q <= imm_i;
                        sub_q <= sub_i;
                        h_q   <= h_in_i;
                    end
                end
                ST_LOWSTEP: begin
                    lo_res_q <= st_sum;
                    cy_q     <= st_cout;
                end
                ST_HIGHSTEP: begin
                    res_o          <= {st_sum, lo_res_q};
                    flags_o[FL_C]  <= st_cout;
                    flags_o[FL_Z]  <= ({st_sum, lo_res_q} == '0);
                    flags_o[FL_N]  <= st_sum[W-1];
                    flags_o[FL_V]  <= st_ovf;
                    flags_o[FL_S]  <= st_sum[W-1] ^ st_ovf;
                    flags_o[FL_H]  <= h_q;
                    done_o         <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/byteflag_alu.sv
module byteflag_alu
    import bfalu_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IMM_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op_i,
    input  logic [DW-1:0]       a_i,
    input  logic [DW-1:0]       b_i,
    input  logic [FLAG_W-1:0]   flags_i,
    output logic [DW-1:0]       res_o,
    output logic [FLAG_W-1:0]   flags_o,
    input  logic                wstart_i,
    input  logic                wsub_i,
    input  logic [DW-1:0]       wlo_i,
    input  logic [DW-1:0]       whi_i,
    input  logic [IMM_W-1:0]    wimm_i,
    output logic                wbusy_o,
    output logic                wdone_o,
    output logic [2*DW-1:0]     wres_o,
    output logic [FLAG_W-1:0]   wflags_o
);
    localparam int WW = 2 * DW;

    logic [WW-1:0] wres;

    bfalu_byte_core #(.W(DW)) u_byte (
        .op_i   (op_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .flags_i(flags_i),
        .res_o  (res_o),
        .flags_o(flags_o)
    );

    bfalu_word_seq #(.W(DW), .IMM_W(IMM_W)) u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(wstart_i),
        .sub_i  (wsub_i),
        .lo_i   (wlo_i),
        .hi_i   (whi_i),
        .imm_i  (wimm_i),
        .h_in_i (flags_i[FL_H]),
        .busy_o (wbusy_o),
        .done_o (wdone_o),
        .res_o  (wres),
        .flags_o(wflags_o)
    );

    assign wres_o = wres;

endmodule

// File: rtl/byteflag_alu_chk.sv
module byteflag_alu_chk
    import bfalu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [7:0]        a_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [7:0]        res_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              wstart_i,
    input logic              wbusy_o,
    input logic              wdone_o,
    input logic [FLAG_W-1:0] wflags_o
);
    // R7
    ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SER) |-> (flags_o == flags_i && res_o == 8'hFF));

    // R3
    logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {OP_AND, OP_OR, OP_XOR, OP_SETB, OP_CLRB, OP_TST, OP_CLR})
        |-> (flags_o[FL_C] == flags_i[FL_C] && flags_o[FL_H] == flags_i[FL_H] && !flags_o[FL_V]));

    // R2
    sbc_zero_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SBC && !flags_i[FL_Z]) |-> !flags_o[FL_Z]);

    // R5
    com_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_COM) |-> (flags_o[FL_C] && !flags_o[FL_V] && res_o == ~a_i));

    // R8
    s_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FL_S] == flags_i[FL_S]);

    // R9
    word_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wstart_i && !wbusy_o) |=> wbusy_o ##1 wbusy_o ##1 (wdone_o && !wbusy_o));

    // R10
    word_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdone_o |-> (wflags_o[FL_S] == (wflags_o[FL_N] ^ wflags_o[FL_V])));

endmodule

bind byteflag_alu byteflag_alu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .a_i     (a_i),
    .flags_i (flags_i),
    .res_o   (res_o),
    .flags_o (flags_o),
    .wstart_i(wstart_i),
    .wbusy_o (wbusy_o),
    .wdone_o (wdone_o),
    .wflags_o(wflags_o)
);

// File: tb/byteflag_alu_test.sv
module byteflag_alu_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op_i;
    logic [7:0]  a_i, b_i, res_o, wlo_i, whi_i;
    logic [5:0]  flags_i, flags_o, wflags_o, wimm_i;
    logic        wstart_i, wsub_i, wbusy_o, wdone_o;
    logic [15:0] wres_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byteflag_alu uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o),
        .wstart_i(wstart_i), .wsub_i(wsub_i), .wlo_i(wlo_i), .whi_i(whi_i),
        .wimm_i(wimm_i), .wbusy_o(wbusy_o), .wdone_o(wdone_o),
        .wres_o(wres_o), .wflags_o(wflags_o)
    );

    function automatic int sx(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic string req_for(int op);
        case (op)
            0, 1:   return "R1";
            2, 3:   return "R2";
            9, 10:  return "R4";
            13:     return "R5";
            14:     return "R6";
            15:     return "R7";
            default: return "R3";
        endcase
    endfunction

    // Reference model, bit order 0 C, 1 Z, 2 N, 3 V, 4 S, 5 H (S never touched: R8).
    function automatic void ref_byte(input int op, input int a, input int b,
                                     input logic [5:0] fi, output int r, output logic [5:0] fo);
        int cc, s, x, y;
        cc = int'(fi[0]);
        fo = fi;
        r  = 0;
        case (op)
            0, 1: begin
                if (op == 0) cc = 0;
                s = a + b + cc;
                r = s % 256;
                fo[0] = (s > 255);
                fo[5] = ((a % 16) + (b % 16) + cc) > 15;
                s = sx(a) + sx(b) + cc;
                fo[3] = (s > 127) || (s < -128);
                fo[1] = (r == 0);
                fo[2] = (r > 127);
            end
            2, 3, 14: begin
                x = a; y = b;
                if (op == 14) begin x = 0; y = a; end
                if (op != 3) cc = 0;
                s = x - y - cc;
                r = (s + 512) % 256;
                fo[0] = (s < 0);
                fo[5] = ((x % 16) - (y % 16) - cc) < 0;
                s = sx(x) - sx(y) - cc;
                fo[3] = (s > 127) || (s < -128);
                fo[1] = (r == 0) && ((op == 3) ? fi[1] : 1'b1);
                fo[2] = (r > 127);
            end
            9, 10: begin
                r = (op == 9) ? (a + 1) % 256 : (a + 255) % 256;
                fo[3] = (op == 9) ? (a == 127) : (a == 128);
                fo[1] = (r == 0);
                fo[2] = (r > 127);
            end
            13: begin
                r = 255 - a;
                fo[0] = 1'b1;
                fo[3] = 1'b0;
                fo[1] = (r == 0);
                fo[2] = (r > 127);
            end
            15: r = 255;
            default: begin
                case (op)
                    4:       r = a & b;
                    5, 7:    r = a | b;
                    6:       r = a ^ b;
                    8:       r = a & (255 - b);
                    11:      r = a;
                    default: r = 0;
                endcase
                fo[3] = 1'b0;
                fo[1] = (r == 0);
                fo[2] = (r > 127);
            end
        endcase
    endfunction

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic check_byte(input int op, input int a, input int b, input logic [5:0] fi);
        int r;
        logic [5:0] fo;
        op_i = 4'(op); a_i = 8'(a); b_i = 8'(b); flags_i = fi;
        #1;
        ref_byte(op, a, b, fi, r, fo);
        n_run++;
        if (res_o !== 8'(r) || flags_o !== fo) begin
            n_fail++;
            if (n_fail < 25)
                $display("FAIL %s op=%0d a=%h b=%h fin=%b: got res=%h flags=%b, expected res=%h flags=%b",
                         req_for(op), op, a, b, fi, res_o, flags_o, 8'(r), fo);
        end
    endtask

    task automatic run_word(input int v, input int imm, input bit sub, input logic [5:0] fi);
        int s, res;
        logic [5:0] ef;
        logic n, vv;
        @(negedge clk);
        whi_i = 8'(v >> 8); wlo_i = 8'(v); wimm_i = 6'(imm); wsub_i = sub;
        flags_i = fi; wstart_i = 1'b1;
        @(negedge clk);
        n_run++;
        if (!(wbusy_o === 1'b1 && wdone_o === 1'b0)) begin
            n_fail++;
            $display("FAIL R9 busy/done after start: got %b/%b, expected 1/0", wbusy_o, wdone_o);
        end
        // Start with altered operands while busy: must be ignored (R9).
        whi_i = ~whi_i; wlo_i = ~wlo_i; wimm_i = ~wimm_i; wsub_i = ~sub; flags_i = ~fi;
        @(negedge clk);
        wstart_i = 1'b0;
        @(negedge clk);
        if (sub) begin s = v - imm; res = (s + 65536) % 65536; end
        else     begin s = v + imm; res = s % 65536; end
        n  = (res > 32767);
        vv = sub ? ((v >= 32768) && (res < 32768)) : ((v < 32768) && (res >= 32768));
        ef = {fi[5], n ^ vv, vv, n, (res == 0), sub ? (s < 0) : (s > 65535)};
        n_run++;
        if (!(wdone_o === 1'b1 && wbusy_o === 1'b0)) begin
            n_fail++;
            $display("FAIL R9 done/busy at step end: got %b/%b, expected 1/0", wdone_o, wbusy_o);
        end
        n_run++;
        if (wres_o !== 16'(res) || wflags_o !== ef) begin
            n_fail++;
            $display("FAIL R10 v=%h imm=%0d sub=%0d: got %h/%b, expected %h/%b",
                     v, imm, sub, wres_o, wflags_o, 16'(res), ef);
        end
        @(negedge clk);
        n_run++;
        if (wdone_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 done not a single pulse: got %b, expected 0", wdone_o);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R9 watchdog expired at %0t: got hang, expected completion", $time);
        report();
        $finish;
    end

    initial begin
        int wv[9] = '{0, 1, 16'h003F, 16'h00FF, 16'h0100, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFC1};
        int imms[5] = '{0, 1, 31, 62, 63};
        rst_n = 1'b0; op_i = '0; a_i = '0; b_i = '0; flags_i = '0;
        wstart_i = 1'b0; wsub_i = 1'b0; wlo_i = '0; whi_i = '0; wimm_i = '0;
        repeat (3) @(negedge clk);
        n_run++;
        if (wbusy_o !== 1'b0 || wdone_o !== 1'b0 || wres_o !== 16'h0 || wflags_o !== 6'h0) begin
            n_fail++;
            $display("FAIL R11 in reset: got busy=%b done=%b res=%h flags=%b, expected 0/0/0000/000000",
                     wbusy_o, wdone_o, wres_o, wflags_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_run++;
        if (wbusy_o !== 1'b0 || wdone_o !== 1'b0 || wres_o !== 16'h0 || wflags_o !== 6'h0) begin
            n_fail++;
            $display("FAIL R11 after reset: got busy=%b done=%b res=%h flags=%b, expected 0/0/0000/000000",
                     wbusy_o, wdone_o, wres_o, wflags_o);
        end

        // Byte sweep: R1..R8 over every first operand and a spread of second operands.
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 20; k++) begin
                    int b;
                    if (k < 16)       b = k * 17;
                    else if (k == 16) b = a;
                    else if (k == 17) b = 128;
                    else if (k == 18) b = 127;
                    else              b = 1;
                    check_byte(op, a, b, 6'(a * 7 + b * 13 + k * 5 + op));
                end
            end
        end

        // Word path: R9, R10.
        for (int i = 0; i < 49; i++) begin
            int v;
            v = (i < 9) ? wv[i] : (((i - 9) * 16'h0F3D + 16'h0123) % 65536);
            for (int j = 0; j < 5; j++) begin
                run_word(v, imms[j], 1'b0, 6'(i * 11 + j * 3));
                run_word(v, imms[j], 1'b1, 6'(i * 5 + j * 7 + 1));
            end
        end

        report();
        $finish;
    end

endmodule